// File: doc/BRIEF.md
# Storage Key Protection Checker

This block guards main memory by attaching a small protection key to every 2 KB block of physical storage and judging each access against it. A key holds a 4-bit access code and one fetch-guard bit. An access presents the address, the kind of operation, the 4-bit access key taken from the running program status word and a flag saying whether the processor is in supervisor state. The block looks up the key of the addressed block and decides whether the access may proceed. The supervisor-state flag is its own input and has nothing to do with interrupt enables.

Two privileged operations maintain the key table: one writes a new key into a block, the other reads a block's key back. Both are refused in problem state. Every request gets exactly one response on the next clock edge. The response is allowed or refused, with a violation kind, the offending address and, for a key read, the key value. The memory contents themselves are not part of this block.

The decision is held as a registered state. IDLE means no request was seen last cycle. PASS means the access or key write was allowed. KEYRD means a key read was allowed and its key is on the output. PROT means a key mismatch blocked the access. PRIV means a key operation was attempted in problem state. Every cycle the state moves to the verdict on the current request. With no request it moves to IDLE. Every transition between any two states is therefore possible in one step.

Top module: `skey_guard`

## Requirements
- R1: After reset every block key is 5'b00000, and all response outputs (resp_valid, resp_ok, resp_viol, viol_kind, viol_addr, key_out) are zero until the first request.
- R2: A request with req_valid high produces resp_valid high on the following cycle, with exactly one of resp_ok and resp_viol high. A cycle without a request produces all response outputs zero on the following cycle.
- R3: A key is laid out as bit 4 = fetch guard and bits 3:0 = access code. Operation codes are 2'b00 read and 2'b01 write. A read or write whose psw_key equals the block's access code is allowed.
- R4: A read or write with psw_key equal to 4'h0 is allowed whatever the block's key.
- R5: A write whose psw_key is non-zero and differs from the block's access code is refused with viol_kind 2'b01 (protection).
- R6: A read whose psw_key is non-zero and differs from the access code is refused with viol_kind 2'b01 when the block's fetch-guard bit is 1. It is allowed when that bit is 0.
- R7: Supervisor state grants no exemption from the key comparison for reads and writes.
- R8: In supervisor state, a set-key request (op 2'b10) writes set_key into the addressed block and is answered with resp_ok. An insert-key request (op 2'b11) is answered with resp_ok and the block's 5-bit key on key_out. Neither consults psw_key. key_out is zero in every other response.
- R9: A set-key or insert-key request in problem state (supv low) is refused with viol_kind 2'b10 (privileged operation), leaves the key table unchanged and gives key_out zero.
- R10: On a refused request viol_addr equals the request's full address. On any other response it is zero.
- R11: The block index is req_addr[16:11] (64 blocks by default). Address bits outside that field do not change which key is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 set key, 11 insert key |
| req_addr | input | ADDR_W | Physical byte address |
| psw_key | input | 4 | Access key from the program status word |
| supv | input | 1 | 1 = supervisor state, 0 = problem state |
| set_key | input | 5 | Key value for a set-key request |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_ok | output | 1 | Request allowed |
| resp_viol | output | 1 | Request refused |
| viol_kind | output | 2 | 00 none, 01 protection, 10 privileged operation |
| viol_addr | output | ADDR_W | Address of the refused request, else zero |
| key_out | output | 5 | Key returned by an allowed insert-key |

## Verification
A corrupted key-table entry stays invisible until that block is touched. The next read, write or insert-key to it then shows a wrong allow or refuse, or a wrong key_out, one cycle after the request. The bench therefore revisits blocks after every key write and sweeps all blocks with insert-key. A wrong decision state shows at the ports in the very cycle after the request it belongs to, as a wrong resp_valid, resp_ok, resp_viol or viol_kind. The reference model is compared on every clock so that such an error is caught at once.

// File: rtl/skey_pkg.sv
package skey_pkg;
    localparam int KEY_W = 5;
    localparam int ACC_W = 4;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SETK  = 2'b10,
        OP_INSK  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS  = 3'd1,
        ST_KEYRD = 3'd2,
        ST_PROT  = 3'd3,
        ST_PRIV  = 3'd4
    } st_e;

    localparam logic [1:0] KIND_NONE = 2'b00;
    localparam logic [1:0] KIND_PROT = 2'b01;
    localparam logic [1:0] KIND_PRIV = 2'b10;
endpackage

// File: rtl/skey_table.sv
module skey_table #(
    parameter int NUM_BLOCKS = 64,
    parameter int IDX_W      = 6,
    parameter int KEY_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [KEY_W-1:0] wkey,
    output logic [KEY_W-1:0] rkey
);
    logic [KEY_W-1:0] ent [NUM_BLOCKS];

    // One key register per block; only the indexed one takes a write.
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        logic [KEY_W-1:0] k_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                k_q <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                k_q <= wkey;
            end
        end
        assign ent[g] = k_q;
    end

    assign rkey = ent[idx];
endmodule

// File: rtl/skey_judge.sv
module skey_judge
    import skey_pkg::*;
(
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [ACC_W-1:0] psw_key,
    input  logic             supv,
    input  logic [KEY_W-1:0] blk_key,
    output st_e              verdict,
    output logic             tbl_we
);
    op_e  op;
    logic code_hit;
    logic guard;

    assign op       = op_e'(req_op);
    assign code_hit = (psw_key == '0) || (psw_key == blk_key[ACC_W-1:0]);
    assign guard    = blk_key[KEY_W-1];

    always_comb begin
        verdict = ST_IDLE;
        tbl_we  = 1'b0;
        if (req_valid) begin
            unique case (op)
                OP_READ:  verdict = (code_hit || !guard) ? ST_PASS : ST_PROT;
                OP_WRITE: verdict = code_hit ? ST_PASS : ST_PROT;
                OP_SETK: begin
                    verdict = supv ? ST_PASS : ST_PRIV;
                    tbl_we  = supv;
                end
                OP_INSK:  verdict = supv ? ST_KEYRD : ST_PRIV;
            endcase
        end
    end
endmodule

// File: rtl/skey_guard.sv
module skey_guard
    import skey_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int NUM_BLOCKS = 64,
    parameter int BLK_SHIFT  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        psw_key,
    input  logic              supv,
    input  logic [4:0]        set_key,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic              resp_viol,
    output logic [1:0]        viol_kind,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [4:0]        key_out
);
    localparam int IDX_W = $clog2(NUM_BLOCKS);

    logic [IDX_W-1:0]  blk_idx;
    logic [KEY_W-1:0]  blk_key;
    logic              tbl_we;
    st_e               verdict;
    st_e               st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [KEY_W-1:0]  key_q;

    assign blk_idx = req_addr[BLK_SHIFT +: IDX_W];

    skey_table #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .IDX_W      (IDX_W),
        .KEY_W      (KEY_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .idx   (blk_idx),
        .wkey  (set_key),
        .rkey  (blk_key)
    );

    skey_judge u_judge (
        .req_valid (req_valid),
        .req_op    (req_op),
        .psw_key   (psw_key),
        .supv      (supv),
        .blk_key   (blk_key),
        .verdict   (verdict),
        .tbl_we    (tbl_we)
    );

    // State register: the decision for last cycle's request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            key_q  <= '0;
        end else begin
            st_q   <= verdict;
            addr_q <= req_addr;
            key_q  <= blk_key;
        end
    end

    // Output decode from the state.
    always_comb begin
        resp_valid = 1'b0;
        resp_ok    = 1'b0;
        resp_viol  = 1'b0;
        viol_kind  = KIND_NONE;
        viol_addr  = '0;
        key_out    = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_PASS: begin
                resp_valid = 1'b1;
                resp_ok    = 1'b1;
            end
            ST_KEYRD: begin
                resp_valid = 1'b1;
                resp_ok    = 1'b1;
                key_out    = key_q;
            end
            ST_PROT: begin
                resp_valid = 1'b1;
                resp_viol  = 1'b1;
                viol_kind  = KIND_PROT;
                viol_addr  = addr_q;
            end
            ST_PRIV: begin
                resp_valid = 1'b1;
                resp_viol  = 1'b1;
                viol_kind  = KIND_PRIV;
                viol_addr  = addr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/skey_guard_chk.sv
module skey_guard_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        psw_key,
    input logic              supv,
    input logic              resp_valid,
    input logic              resp_ok,
    input logic              resp_viol,
    input logic [1:0]        viol_kind,
    input logic [ADDR_W-1:0] viol_addr,
    input logic [4:0]        key_out
);
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    a_r2_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    a_r2_ok_viol_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_ok, resp_viol}) && (resp_valid == (resp_ok || resp_viol)));
    a_r4_zero_key_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1] && psw_key == 4'h0) |=> resp_ok);
    a_r9_priv_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && !supv) |=> (resp_viol && viol_kind == 2'b10));
    a_r10_viol_addr: assert property (@(posedge clk) disable iff (!rst_n)
        resp_viol |-> (viol_addr == $past(req_addr)));
    a_r8_key_out_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (key_out != 5'd0) |-> resp_ok);
endmodule

bind skey_guard skey_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .psw_key    (psw_key),
    .supv       (supv),
    .resp_valid (resp_valid),
    .resp_ok    (resp_ok),
    .resp_viol  (resp_viol),
    .viol_kind  (viol_kind),
    .viol_addr  (viol_addr),
    .key_out    (key_out)
);

// File: tb/sim_skey_guard.sv
`timescale 1ns/1ps
module sim_skey_guard;
    localparam int ADDR_W = 20;
    localparam int NB     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        psw_key = 4'h0;
    logic              supv = 1'b0;
    logic [4:0]        set_key = 5'd0;
    logic              resp_valid, resp_ok, resp_viol;
    logic [1:0]        viol_kind;
    logic [ADDR_W-1:0] viol_addr;
    logic [4:0]        key_out;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;
    logic [4:0] mkey [NB];

    always #2.5 clk = ~clk;

    skey_guard #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NB), .BLK_SHIFT(11)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .psw_key(psw_key), .supv(supv), .set_key(set_key),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_viol(resp_viol),
        .viol_kind(viol_kind), .viol_addr(viol_addr), .key_out(key_out)
    );

    // Packed view: {valid, ok, viol, kind, addr, key}
    function automatic logic [30:0] seen();
        return {resp_valid, resp_ok, resp_viol, viol_kind, viol_addr, key_out};
    endfunction

    task automatic compare(input string tag, input logic [30:0] exp);
        n_cmp++;
        if (seen() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, seen(), exp);
        end
    endtask

    // Drive one cycle (valid or idle) just after a negedge, model it,
    // then compare at the following negedge.
    task automatic step(input string tag, input bit v, input logic [1:0] op,
                        input logic [ADDR_W-1:0] a, input logic [3:0] pk,
                        input bit sv, input logic [4:0] sk);
        logic [30:0] exp;
        int          idx;
        logic [4:0]  k;
        bit          hit;
        req_valid = v; req_op = op; req_addr = a;
        psw_key = pk; supv = sv; set_key = sk;
        idx = int'(a[16:11]);
        k   = mkey[idx];
        hit = (pk == 4'h0) || (pk == k[3:0]);
        exp = '0;
        if (v) begin
            case (op)
                2'b00: exp = (hit || !k[4]) ? {3'b110, 2'b00, 20'h0, 5'd0}
                                            : {3'b101, 2'b01, a, 5'd0};
                2'b01: exp = hit ? {3'b110, 2'b00, 20'h0, 5'd0}
                                 : {3'b101, 2'b01, a, 5'd0};
                2'b10: begin
                    if (sv) begin
                        exp = {3'b110, 2'b00, 20'h0, 5'd0};
                        mkey[idx] = sk;
                    end else begin
                        exp = {3'b101, 2'b10, a, 5'd0};
                    end
                end
                default: exp = sv ? {3'b110, 2'b00, 20'h0, k}
                                  : {3'b101, 2'b10, a, 5'd0};
            endcase
        end
        @(negedge clk);
        compare(tag, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) mkey[i] = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 outputs after reset", '0);

        // R1: every key reads back as zero
        for (int i = 0; i < NB; i++)
            step("R1 key reset sweep", 1, 2'b11, ADDR_W'(i << 11), 4'h9, 1, 5'd0);

        step("R8 set key blk3", 1, 2'b10, 20'h01800, 4'h5, 1, 5'b0_0110);
        step("R8 insert key blk3", 1, 2'b11, 20'h01840, 4'h2, 1, 5'd0);
        step("R3 read match", 1, 2'b00, 20'h01900, 4'h6, 0, 5'd0);
        step("R3 write match", 1, 2'b01, 20'h01904, 4'h6, 0, 5'd0);
        step("R6 read mismatch unguarded", 1, 2'b00, 20'h01a00, 4'h7, 0, 5'd0);
        step("R5 write mismatch", 1, 2'b01, 20'h01a10, 4'h7, 0, 5'd0);
        step("R2 idle after request", 0, 2'b00, 20'h0, 4'h0, 0, 5'd0);
        step("R8 set guarded key", 1, 2'b10, 20'h01800, 4'h0, 1, 5'b1_0110);
        step("R6 read mismatch guarded", 1, 2'b00, 20'h01b20, 4'h7, 0, 5'd0);
        step("R4 read psw key zero", 1, 2'b00, 20'h01b20, 4'h0, 0, 5'd0);
        step("R4 write psw key zero", 1, 2'b01, 20'h01b24, 4'h0, 0, 5'd0);
        step("R7 supervisor write mismatch", 1, 2'b01, 20'h01c00, 4'h7, 1, 5'd0);
        step("R7 supervisor read guarded", 1, 2'b00, 20'h01c00, 4'h3, 1, 5'd0);
        step("R9 problem-state set key", 1, 2'b10, 20'h01800, 4'h6, 0, 5'b1_1111);
        step("R9 table unchanged", 1, 2'b11, 20'h01800, 4'h6, 1, 5'd0);
        step("R9 problem-state insert", 1, 2'b11, 20'h01800, 4'h6, 0, 5'd0);
        step("R10 refused address", 1, 2'b01, 20'h01ffe, 4'hf, 0, 5'd0);
        step("R11 upper bits alias blk3", 1, 2'b00, 20'he1800, 4'h5, 0, 5'd0);
        step("R11 upper bits alias insert", 1, 2'b11, 20'hf9a00, 4'h5, 1, 5'd0);
        step("R8 last block set", 1, 2'b10, 20'h1f800, 4'h1, 1, 5'b1_1010);
        step("R5 last block write", 1, 2'b01, 20'h1ffff, 4'hb, 0, 5'd0);
        step("R3 last block read", 1, 2'b00, 20'h1f800, 4'ha, 0, 5'd0);

        // Mixed traffic checked against the model every cycle.
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] op_r;
            op_r = 2'($urandom);
            step("R2 R3 R5 R6 R8 R9 mixed", ($urandom % 5) != 0, op_r,
                 ADDR_W'($urandom), 4'($urandom % 4 == 0 ? 0 : $urandom),
                 1'($urandom), 5'($urandom));
        end
        step("R2 final idle", 0, 2'b00, 20'h0, 4'h0, 0, 5'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule